// File: doc/BRIEF.md
# Serial Channel Loopback Controller

This block decides, for each of sixteen serial channels, which path the channel's data takes: normal routing, self-test loopback (the channel's transmit data turned back into its own receiver), or line-side loopback (the data arriving on the channel's receiver sent straight back out of its transmitter). Three mode pins choose the loopback: a self-test loopback request, a half-width qualifier, and a line-side loopback request. A per-channel enable register, written through a small byte-wide configuration port, adds line-side loopback for single channels. The serial lanes and the test-pattern source sit outside this block. It drives one 2-bit path code per channel to the lane multiplexers.

Self-test loopback and line-side loopback are never active at the same time. If both are requested, self-test wins, every line-side path is forced off, and a conflict flag rises. The configuration port has a 6-bit address, an active-low select and a direction line that is high for read and low for write. It returns read data one cycle after the request, together with an output-enable line. An external pad can use that enable to tristate the shared data bus.

The external reset is asserted asynchronously and released through a two-stage synchronizer. All state therefore starts to move on the third rising clock edge after `rst_n` goes high.

Top module: `lpbk_ctrl_unit`

## Requirements
- R1: While reset is asserted, and until the third rising edge after its release, every channel code is normal (2'b00), the enable register is 0, `conflict_o` is 0 and `cfg_rdata_oe_o` is 0.
- R2: With `bist_lpbk_i` high and `bist_half_i` low, every channel code becomes self-test (2'b01) on the next rising edge. Channel n's code is at `chan_mode_o[2n+1:2n]`.
- R3: With `bist_lpbk_i` and `bist_half_i` both high, channels 0 to 7 take code 2'b01 and channels 8 to 15 take code 2'b00 on the next edge.
- R4: With `bist_lpbk_i` low and `fac_lpbk_i` high, every channel code becomes line-side (2'b10) on the next edge.
- R5: With `bist_lpbk_i` low, a channel whose enable register bit is 1 takes code 2'b10 on the next edge, and a channel whose bit is 0 takes 2'b00 unless `fac_lpbk_i` is high.
- R6: While `bist_lpbk_i` is high, no channel ever shows 2'b10. `conflict_o` is 1 on the edge after any cycle in which `bist_lpbk_i` is high together with `fac_lpbk_i` high or a nonzero enable register, and 0 after any other cycle.
- R7: A write (select low, direction low) to address 0 loads register bits 7:0 (channels 0 to 7, bit n for channel n). A write to address 1 loads bits 15:8 (channels 8 to 15). The new value takes effect at the edge of the write. Writes to any other address change nothing.
- R8: A read (select low, direction high) sets `cfg_rdata_oe_o` on the next edge and presents data there. Address 0 and address 1 return the two register bytes. Address 2 returns the conflict flag in bit 0, with the other bits 0. All other addresses return 0. While the enable is low, `cfg_rdata_o` is 0.
- R9: With the select line high, `cfg_rdata_oe_o` is 0 on the next edge and no write takes place, whatever the address, direction and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bist_lpbk_i | input | 1 | Self-test loopback request |
| bist_half_i | input | 1 | Limits self-test loopback to channels 0 to 7 |
| fac_lpbk_i | input | 1 | Line-side loopback request for all channels |
| cfg_addr_i | input | 6 | Configuration register address |
| cfg_cs_n_i | input | 1 | Configuration select, active low |
| cfg_rd_i | input | 1 | 1 = read, 0 = write |
| cfg_wdata_i | input | 8 | Write data |
| cfg_rdata_o | output | 8 | Read data, zero when not enabled |
| cfg_rdata_oe_o | output | 1 | Read data output enable for the bus pads |
| chan_mode_o | output | 32 | Path code per channel: 00 normal, 01 self-test, 10 line-side |
| conflict_o | output | 1 | Both loopback kinds were requested in the previous cycle |

## Verification
Each result has a fixed latency:
- Channel codes and the conflict flag follow the mode pins and the enable register one rising edge later.
- A register write changes the channel codes on the edge after the write edge.
- Read data and its enable appear on the edge after the request.
- Nothing moves until the third edge after reset release.

The bench holds a behavioural model that advances by these delays on every rising edge. It compares all outputs on the following falling edge, so each value is sampled only after the register that produces it has settled. The stimulus changes inputs on falling edges, which lets the model and the design see the same values at each rising edge.

// File: rtl/lpbk_pkg.sv
package lpbk_pkg;

  typedef enum logic [1:0] {
    PATH_NORMAL = 2'b00,
    PATH_BIST   = 2'b01,
    PATH_FAC    = 2'b10
  } path_e;

endpackage

// File: rtl/lpbk_rst_sync.sv
module lpbk_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;

endmodule

// File: rtl/lpbk_regfile.sv
module lpbk_regfile #(
  parameter int NCH = 16,
  parameter int AW  = 6,
  parameter int DW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  addr_i,
  input  logic           cs_n_i,
  input  logic           rd_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic           status_i,
  output logic [NCH-1:0] lpbk_o,
  output logic [DW-1:0]  rdata_o,
  output logic           oe_o
);

  localparam int NBYTES    = NCH / DW;
  localparam int STAT_ADDR = NBYTES;

  logic [NCH-1:0] lpbk_q, lpbk_d;
  logic [DW-1:0]  rdata_q, rdata_d;
  logic           oe_q, oe_d;
  logic           wr_en, rd_en;

  assign wr_en = !cs_n_i && !rd_i;
  assign rd_en = !cs_n_i &&  rd_i;

  // next state: byte-lane writes
  always_comb begin
    lpbk_d = lpbk_q;
    for (int b = 0; b < NBYTES; b++) begin
      if (wr_en && (addr_i == AW'(b))) begin
        lpbk_d[b*DW +: DW] = wdata_i;
      end
    end
  end

  // next state: read mux
  always_comb begin
    rdata_d = '0;
    for (int b = 0; b < NBYTES; b++) begin
      if (addr_i == AW'(b)) begin
        rdata_d = lpbk_q[b*DW +: DW];
      end
    end
    if (addr_i == AW'(STAT_ADDR)) begin
      rdata_d = {{(DW-1){1'b0}}, status_i};
    end
    oe_d = rd_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lpbk_q  <= '0;
      rdata_q <= '0;
      oe_q    <= 1'b0;
    end else begin
      if (wr_en) lpbk_q <= lpbk_d;
      if (rd_en) rdata_q <= rdata_d;
      oe_q <= oe_d;
    end
  end

  assign lpbk_o  = lpbk_q;
  assign oe_o    = oe_q;
  assign rdata_o = oe_q ? rdata_q : '0;

  // R9: a deselected cycle never drives the bus
  a_r9_no_drive_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n_i) |-> !oe_o);

  // R9: a deselected cycle never changes the enable register
  a_r9_no_write_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n_i) |-> $stable(lpbk_q));

  // R8: bus is quiet while the enable is low
  a_r8_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_o |-> (rdata_o == '0));

endmodule

// File: rtl/lpbk_route.sv
module lpbk_route
  import lpbk_pkg::*;
#(
  parameter int NCH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bist_i,
  input  logic             half_i,
  input  logic             fac_i,
  input  logic [NCH-1:0]   lpbk_i,
  output logic [2*NCH-1:0] mode_o,
  output logic             conflict_o
);

  localparam int HALF = NCH / 2;

  path_e       mode_d [NCH];
  path_e       mode_q [NCH];
  logic        conflict_d, conflict_q;
  logic [NCH-1:0] is_bist, is_fac;

  assign conflict_d = bist_i && (fac_i || (|lpbk_i));

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    always_comb begin
      if (bist_i && (!half_i || (ch < HALF))) begin
        mode_d[ch] = PATH_BIST;
      end else if (!bist_i && (fac_i || lpbk_i[ch])) begin
        mode_d[ch] = PATH_FAC;
      end else begin
        mode_d[ch] = PATH_NORMAL;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q[ch] <= PATH_NORMAL;
      else        mode_q[ch] <= mode_d[ch];
    end

    assign mode_o[2*ch +: 2] = mode_q[ch];
    assign is_bist[ch] = (mode_q[ch] == PATH_BIST);
    assign is_fac[ch]  = (mode_q[ch] == PATH_FAC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) conflict_q <= 1'b0;
    else        conflict_q <= conflict_d;
  end

  assign conflict_o = conflict_q;

  // R6: the two loopback kinds never coexist across the channels
  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !((|is_bist) && (|is_fac)));

  // R6: a flagged conflict means line-side loopback is off everywhere
  a_r6_conflict_suppresses: assert property (@(posedge clk) disable iff (!rst_n)
    conflict_o |-> (is_fac == '0));

  // R3: half-width self-test leaves the upper channels normal
  a_r3_upper_normal: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bist_i && half_i) |-> (is_bist[NCH-1:HALF] == '0) && (is_fac == '0));

endmodule

// File: rtl/lpbk_ctrl_unit.sv
module lpbk_ctrl_unit #(
  parameter int NCH = 16,
  parameter int AW  = 6,
  parameter int DW  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bist_lpbk_i,
  input  logic             bist_half_i,
  input  logic             fac_lpbk_i,
  input  logic [AW-1:0]    cfg_addr_i,
  input  logic             cfg_cs_n_i,
  input  logic             cfg_rd_i,
  input  logic [DW-1:0]    cfg_wdata_i,
  output logic [DW-1:0]    cfg_rdata_o,
  output logic             cfg_rdata_oe_o,
  output logic [2*NCH-1:0] chan_mode_o,
  output logic             conflict_o
);

  logic           rst_int_n;
  logic [NCH-1:0] lpbk_en;

  lpbk_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  lpbk_regfile #(.NCH(NCH), .AW(AW), .DW(DW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .addr_i   (cfg_addr_i),
    .cs_n_i   (cfg_cs_n_i),
    .rd_i     (cfg_rd_i),
    .wdata_i  (cfg_wdata_i),
    .status_i (conflict_o),
    .lpbk_o   (lpbk_en),
    .rdata_o  (cfg_rdata_o),
    .oe_o     (cfg_rdata_oe_o)
  );

  lpbk_route #(.NCH(NCH)) u_route (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .bist_i     (bist_lpbk_i),
    .half_i     (bist_half_i),
    .fac_i      (fac_lpbk_i),
    .lpbk_i     (lpbk_en),
    .mode_o     (chan_mode_o),
    .conflict_o (conflict_o)
  );

endmodule

// File: tb/tb_lpbk_ctrl_unit.sv
`timescale 1ns/1ps
module tb_lpbk_ctrl_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bist = 1'b0, half = 1'b0, fac = 1'b0;
  logic [5:0]  addr = '0;
  logic        cs_n = 1'b1, rd = 1'b1;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        oe;
  logic [31:0] mode;
  logic        conf;

  always #10 clk = ~clk;  // 50 MHz

  lpbk_ctrl_unit dut (
    .clk(clk), .rst_n(rst_n),
    .bist_lpbk_i(bist), .bist_half_i(half), .fac_lpbk_i(fac),
    .cfg_addr_i(addr), .cfg_cs_n_i(cs_n), .cfg_rd_i(rd), .cfg_wdata_i(wdata),
    .cfg_rdata_o(rdata), .cfg_rdata_oe_o(oe),
    .chan_mode_o(mode), .conflict_o(conf)
  );

  // behavioural reference model
  int          rel_cnt = 0;
  logic [15:0] m_lp = '0;
  logic [31:0] m_mode = '0;
  logic        m_conf = 1'b0, m_oe = 1'b0;
  logic [7:0]  m_rdata = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_cnt = 0; m_lp = '0; m_mode = '0; m_conf = 0; m_oe = 0; m_rdata = '0;
    end else if (rel_cnt < 2) begin
      rel_cnt++;
    end else begin
      logic [15:0] nlp;
      nlp = m_lp;
      if (!cs_n && !rd) begin
        if (addr == 0) nlp[7:0]  = wdata;
        if (addr == 1) nlp[15:8] = wdata;
      end
      m_oe = !cs_n && rd;
      if (!cs_n && rd) begin
        case (addr)
          6'd0: m_rdata = m_lp[7:0];
          6'd1: m_rdata = m_lp[15:8];
          6'd2: m_rdata = {7'b0, m_conf};
          default: m_rdata = 8'h00;
        endcase
      end
      for (int ch = 0; ch < 16; ch++) begin
        if (bist && (!half || ch < 8))        m_mode[2*ch +: 2] = 2'b01;
        else if (!bist && (fac || m_lp[ch]))  m_mode[2*ch +: 2] = 2'b10;
        else                                  m_mode[2*ch +: 2] = 2'b00;
      end
      m_conf = bist && (fac || (m_lp != 0));
      m_lp = nlp;
    end
  end

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R1";

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    check(cur_req, "chan_mode", mode, m_mode);
    check((cur_req == "R2" || cur_req == "R3") ? "R6" : cur_req, "conflict", {31'b0, conf}, {31'b0, m_conf});
    check(cur_req, "rdata_oe", {31'b0, oe}, {31'b0, m_oe});
    check(cur_req, "rdata", {24'b0, rdata}, {24'b0, (m_oe ? m_rdata : 8'h00)});
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cs_n = 1'b1; rd = 1'b1;
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; rd = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    cs_n = 1'b1; rd = 1'b1;
  endtask

  task automatic rdreg(input logic [5:0] a);
    @(negedge clk);
    cs_n = 1'b0; rd = 1'b1; addr = a;
    @(negedge clk);
    cs_n = 1'b1;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    // R1: reset and synchronizer release
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    // R7: byte writes, then R5 per-channel line-side loopback
    cur_req = "R7";
    wr(6'd0, 8'hA5);
    wr(6'd1, 8'h3C);
    cur_req = "R5";
    idle(3);
    // R8: readback of both bytes, status and an unused address
    cur_req = "R8";
    rdreg(6'd0); rdreg(6'd1); rdreg(6'd2); rdreg(6'd37);
    idle(2);
    // R7: write to status and unused addresses changes nothing
    cur_req = "R7";
    wr(6'd2, 8'hFF); wr(6'd9, 8'hFF);
    rdreg(6'd0); rdreg(6'd1);
    // R4: line-side pin on all channels
    cur_req = "R4";
    @(negedge clk); fac = 1'b1;
    idle(3);
    // R2: full self-test with line-side requested: conflict, R6
    cur_req = "R2";
    @(negedge clk); bist = 1'b1;
    idle(3);
    rdreg(6'd2);
    // R3: half-width self-test
    cur_req = "R3";
    @(negedge clk); half = 1'b1;
    idle(3);
    @(negedge clk); fac = 1'b0;
    idle(2);
    // R6: clear register, self-test alone leaves no conflict
    cur_req = "R6";
    wr(6'd0, 8'h00); wr(6'd1, 8'h00);
    idle(2);
    rdreg(6'd2);
    @(negedge clk); bist = 1'b0; half = 1'b0;
    // R9: deselected write attempts and reads are ignored
    cur_req = "R9";
    @(negedge clk); cs_n = 1'b1; rd = 1'b0; addr = 6'd0; wdata = 8'hFF;
    @(negedge clk); addr = 6'd1;
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b1; cs_n = 1'b1;
    idle(2);
    rdreg(6'd0); rdreg(6'd1);
    // R5: single channel enables at the byte edges
    cur_req = "R5";
    wr(6'd0, 8'h81); wr(6'd1, 8'h01);
    idle(3);
    // R1: reset again mid-run
    cur_req = "R1";
    @(negedge clk); rst_n = 1'b0;
    idle(2);
    @(negedge clk); rst_n = 1'b1;
    idle(4);
    finish_run();
  end

endmodule